// File: doc/BRIEF.md
# Audio Control Command Decoder

This block sits behind a serial slave receiver in an audio processor. It receives the slave's start and stop indications together with a strobe for each received byte. Within a transfer, the first byte is a device address. When that address matches the block's own, each byte that follows is read as a command and decoded by its leading bits. A command writes one of eight control registers: the main volume, four speaker attenuators (left-front, right-front, left-rear, right-rear), the input selector, bass, or treble. One transfer can carry any number of commands, and each command is decoded independently.

Each register is presented in two forms. One is its raw code. The other is a signed gain in half-decibel units, which the analog control logic downstream can use directly. A command that carries a code outside the legal set leaves its register as it was and raises an error pulse. Every accepted command raises a one-cycle update pulse for the register it wrote. Pop-free or zero-cross switching logic can use that pulse to time the change.

Top module: `audcmd_top`

## Requirements
- R1: A session state machine has four states. In IDLE, nothing is open. In ADDR, a start has been seen and the next byte is an address. In OPEN, the address matched. In SKIP, the address did not match. A start moves any state to ADDR. A stop moves any state to IDLE. In ADDR, a byte equal to DEV_ADDR (default 8'h88, all 8 bits compared) moves to OPEN, and any other byte moves to SKIP. Bytes received in IDLE, ADDR or SKIP write no register.
- R2: In OPEN, a byte 2'b00,B[2:0],A[2:0] sets the volume code to {B,A}. The volume gain is 20 − 20·B − 4·A half-dB. For example, 8'h21 gives −64 (−32 dB).
- R3: A byte 1'b1,P[1:0],B[1:0],A[2:0] sets speaker P to code {B,A}. P=0 is left-front, 1 is right-front, 2 is left-rear and 3 is right-rear. Speaker P's code sits at bits [5P+4:5P] and its gain at bits [9P+8:9P]. The gain is −20·B − 4·A half-dB. For example, 8'hB2 gives right-front −48.
- R4: A byte 3'b010,x,x,S[2:0] sets the selector to S. Codes 0 to 3 select stereo inputs 1 to 4 and code 4 selects mono. Bits 4 and 3 have no effect.
- R5: A byte 4'b0110,C sets bass and 4'b0111,C sets treble. When C[3]=0 the setting is a cut. C=0 and C=1 give −30 half-dB. C=2 to 7 give −25, −20, −15, −10, −5 and 0.
- R6: When C[3]=1 the setting is a boost. C=15 to 10 give 0, 5, 10, 15, 20 and 25 half-dB. C=9 and C=8 both saturate at +30.
- R7: A volume or speaker byte with A>4, or a selector byte with S>4, leaves every register unchanged. It raises cmd_err for exactly one cycle and raises no update pulse.
- R8: After reset, the volume code is 6'b111100 (−136). Every speaker code is 5'b11100 (−76). The selector is 4 (mono). Bass and treble are both 4'b1110 (+5).
- R9: An accepted command writes its register and raises upd for one cycle at the same clock edge. The upd bit order is: bit 0 volume, bits 1 to 4 speakers 0 to 3, bit 5 selector, bit 6 bass, bit 7 treble. No register changes without its upd bit.
- R10: Any number of commands may follow one matching address. All of them are applied until a stop or a new start.
- R11: When a start or a stop arrives in the same cycle as a byte strobe, the start or stop takes effect and the byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_det | input | 1 | Start condition seen by the serial slave |
| stop_det | input | 1 | Stop condition seen by the serial slave |
| byte_valid | input | 1 | One-cycle strobe for a received byte |
| byte_data | input | 8 | Received byte |
| vol_code | output | 6 | Volume code |
| vol_db | output | 9 | Volume gain, signed half-dB |
| spk_code | output | 20 | Four speaker codes, 5 bits each |
| spk_db | output | 36 | Four speaker gains, signed half-dB, 9 bits each |
| sel_code | output | 3 | Input selector code |
| bass_code | output | 4 | Bass code |
| bass_db | output | 8 | Bass gain, signed half-dB |
| treble_code | output | 4 | Treble code |
| treble_db | output | 8 | Treble gain, signed half-dB |
| upd | output | 8 | One-cycle update pulse per register |
| cmd_err | output | 1 | One-cycle pulse for a rejected command |

## Verification
A byte strobe can coincide with a start or a stop, and in that cycle the session control and the command write compete. The bench drives a byte in the same cycle as a start, and again in the same cycle as a stop. It expects no update, no error, and unchanged registers. It then checks that the session state that follows is ADDR or IDLE, by sending a further command and observing whether it is applied. Random transfers also place starts and stops next to byte strobes.

// File: rtl/audcmd_pkg.sv
package audcmd_pkg;

    localparam int SPK_N  = 4;
    localparam int VOL_W  = 6;
    localparam int SPK_W  = 5;
    localparam int SEL_W  = 3;
    localparam int TONE_W = 4;
    localparam int DB_W   = 9;
    localparam int TDB_W  = 8;
    localparam int UPD_N  = 1 + SPK_N + 3;
    localparam int FINE_MAX = 4;

    localparam int UPD_VOL  = 0;
    localparam int UPD_SPK0 = 1;
    localparam int UPD_SEL  = UPD_SPK0 + SPK_N;
    localparam int UPD_BASS = UPD_SEL + 1;
    localparam int UPD_TREB = UPD_BASS + 1;

    localparam logic [VOL_W-1:0]  VOL_RST  = 6'b111_100;
    localparam logic [SPK_W-1:0]  SPK_RST  = 5'b11_100;
    localparam logic [SEL_W-1:0]  SEL_RST  = 3'd4;
    localparam logic [TONE_W-1:0] TONE_RST = 4'b1110;

    typedef enum logic [2:0] {
        TGT_VOL,
        TGT_SPK,
        TGT_SEL,
        TGT_BASS,
        TGT_TREB
    } tgt_e;

    typedef struct packed {
        tgt_e        tgt;
        logic [1:0]  spk;
        logic [5:0]  field;
        logic        bad;
    } cmd_t;

    function automatic logic signed [DB_W-1:0] vol_half_db(input logic [VOL_W-1:0] c);
        int v;
        v = 20 - 20 * int'(c[5:3]) - 4 * int'(c[2:0]);
        return DB_W'(v);
    endfunction

    function automatic logic signed [DB_W-1:0] spk_half_db(input logic [SPK_W-1:0] c);
        int v;
        v = -20 * int'(c[4:3]) - 4 * int'(c[2:0]);
        return DB_W'(v);
    endfunction

    function automatic logic signed [TDB_W-1:0] tone_half_db(input logic [TONE_W-1:0] c);
        int m;
        int v;
        if (!c[3]) begin
            m = (c[2:0] == 3'd0) ? 1 : int'(c[2:0]);
            v = -30 + 5 * (m - 1);
        end else begin
            m = 7 - int'(c[2:0]);
            if (m > 6) m = 6;
            v = 5 * m;
        end
        return TDB_W'(v);
    endfunction

endpackage

// File: rtl/audcmd_link.sv
module audcmd_link #(
    parameter logic [7:0] DEV_ADDR = 8'h88
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       data_en
);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_OPEN,
        ST_SKIP
    } link_e;

    link_e state_q, state_d;
    logic  ctl_evt;

    assign ctl_evt = start_det | stop_det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        data_en = 1'b0;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: begin
                    if (byte_valid)
                        state_d = (byte_data == DEV_ADDR) ? ST_OPEN : ST_SKIP;
                end
                ST_OPEN: state_d = ST_OPEN;
                ST_SKIP: state_d = ST_SKIP;
                default: state_d = ST_IDLE;
            endcase
        end
        unique case (state_q)
            ST_OPEN: data_en = byte_valid & ~ctl_evt;
            ST_IDLE, ST_ADDR, ST_SKIP: data_en = 1'b0;
            default: data_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/audcmd_decode.sv
module audcmd_decode
    import audcmd_pkg::*;
(
    input  logic [7:0] byte_data,
    output cmd_t       cmd
);

    always_comb begin
        cmd.spk   = 2'd0;
        cmd.field = 6'd0;
        cmd.bad   = 1'b0;
        cmd.tgt   = TGT_VOL;
        if (byte_data[7]) begin
            cmd.tgt   = TGT_SPK;
            cmd.spk   = byte_data[6:5];
            cmd.field = {1'b0, byte_data[4:0]};
            cmd.bad   = int'(byte_data[2:0]) > FINE_MAX;
        end else if (!byte_data[6]) begin
            cmd.tgt   = TGT_VOL;
            cmd.field = byte_data[5:0];
            cmd.bad   = int'(byte_data[2:0]) > FINE_MAX;
        end else if (!byte_data[5]) begin
            cmd.tgt   = TGT_SEL;
            cmd.field = {3'd0, byte_data[2:0]};
            cmd.bad   = int'(byte_data[2:0]) > FINE_MAX;
        end else if (!byte_data[4]) begin
            cmd.tgt   = TGT_BASS;
            cmd.field = {2'd0, byte_data[3:0]};
        end else begin
            cmd.tgt   = TGT_TREB;
            cmd.field = {2'd0, byte_data[3:0]};
        end
    end

endmodule

// File: rtl/audcmd_regbank.sv
module audcmd_regbank
    import audcmd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_en,
    input  cmd_t                    cmd,
    output logic [VOL_W-1:0]        vol_q,
    output logic [SPK_N*SPK_W-1:0]  spk_q,
    output logic [SEL_W-1:0]        sel_q,
    output logic [TONE_W-1:0]       bass_q,
    output logic [TONE_W-1:0]       treb_q,
    output logic [UPD_N-1:0]        upd_q,
    output logic                    err_q
);

    logic             wr_ok;
    logic [UPD_N-1:0] wr_sel;

    assign wr_ok = cmd_en & ~cmd.bad;

    always_comb begin
        wr_sel = '0;
        if (wr_ok) begin
            unique case (cmd.tgt)
                TGT_VOL:  wr_sel[UPD_VOL]  = 1'b1;
                TGT_SPK:  wr_sel[UPD_SPK0 + int'(cmd.spk)] = 1'b1;
                TGT_SEL:  wr_sel[UPD_SEL]  = 1'b1;
                TGT_BASS: wr_sel[UPD_BASS] = 1'b1;
                TGT_TREB: wr_sel[UPD_TREB] = 1'b1;
                default:  wr_sel = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vol_q  <= VOL_RST;
            sel_q  <= SEL_RST;
            bass_q <= TONE_RST;
            treb_q <= TONE_RST;
            upd_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_sel[UPD_VOL])  vol_q  <= cmd.field[VOL_W-1:0];
            if (wr_sel[UPD_SEL])  sel_q  <= cmd.field[SEL_W-1:0];
            if (wr_sel[UPD_BASS]) bass_q <= cmd.field[TONE_W-1:0];
            if (wr_sel[UPD_TREB]) treb_q <= cmd.field[TONE_W-1:0];
            upd_q <= wr_sel;
            err_q <= cmd_en & cmd.bad;
        end
    end

    for (genvar i = 0; i < SPK_N; i++) begin : g_spk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                spk_q[i*SPK_W +: SPK_W] <= SPK_RST;
            else if (wr_sel[UPD_SPK0 + i])
                spk_q[i*SPK_W +: SPK_W] <= cmd.field[SPK_W-1:0];
        end
    end

endmodule

// File: rtl/audcmd_scale.sv
module audcmd_scale
    import audcmd_pkg::*;
(
    input  logic [VOL_W-1:0]       vol_q,
    input  logic [SPK_N*SPK_W-1:0] spk_q,
    input  logic [TONE_W-1:0]      bass_q,
    input  logic [TONE_W-1:0]      treb_q,
    output logic [DB_W-1:0]        vol_db,
    output logic [SPK_N*DB_W-1:0]  spk_db,
    output logic [TDB_W-1:0]       bass_db,
    output logic [TDB_W-1:0]       treb_db
);

    assign vol_db  = vol_half_db(vol_q);
    assign bass_db = tone_half_db(bass_q);
    assign treb_db = tone_half_db(treb_q);

    for (genvar i = 0; i < SPK_N; i++) begin : g_spk
        assign spk_db[i*DB_W +: DB_W] = spk_half_db(spk_q[i*SPK_W +: SPK_W]);
    end

endmodule

// File: rtl/audcmd_top.sv
module audcmd_top
    import audcmd_pkg::*;
#(
    parameter logic [7:0] DEV_ADDR = 8'h88
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_det,
    input  logic                    stop_det,
    input  logic                    byte_valid,
    input  logic [7:0]              byte_data,
    output logic [VOL_W-1:0]        vol_code,
    output logic [DB_W-1:0]         vol_db,
    output logic [SPK_N*SPK_W-1:0]  spk_code,
    output logic [SPK_N*DB_W-1:0]   spk_db,
    output logic [SEL_W-1:0]        sel_code,
    output logic [TONE_W-1:0]       bass_code,
    output logic [TDB_W-1:0]        bass_db,
    output logic [TONE_W-1:0]       treble_code,
    output logic [TDB_W-1:0]        treble_db,
    output logic [UPD_N-1:0]        upd,
    output logic                    cmd_err
);

    logic data_en;
    cmd_t cmd;

    audcmd_link #(.DEV_ADDR(DEV_ADDR)) link_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .data_en    (data_en)
    );

    audcmd_decode dec_i (
        .byte_data (byte_data),
        .cmd       (cmd)
    );

    audcmd_regbank regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_en (data_en),
        .cmd    (cmd),
        .vol_q  (vol_code),
        .spk_q  (spk_code),
        .sel_q  (sel_code),
        .bass_q (bass_code),
        .treb_q (treble_code),
        .upd_q  (upd),
        .err_q  (cmd_err)
    );

    audcmd_scale scale_i (
        .vol_q   (vol_code),
        .spk_q   (spk_code),
        .bass_q  (bass_code),
        .treb_q  (treble_code),
        .vol_db  (vol_db),
        .spk_db  (spk_db),
        .bass_db (bass_db),
        .treb_db (treble_db)
    );

endmodule

// File: rtl/audcmd_chk.sv
module audcmd_chk
    import audcmd_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start_det,
    input logic                    stop_det,
    input logic                    byte_valid,
    input logic [VOL_W-1:0]        vol_code,
    input logic [SPK_N*SPK_W-1:0]  spk_code,
    input logic [SEL_W-1:0]        sel_code,
    input logic [TDB_W-1:0]        bass_db,
    input logic [UPD_N-1:0]        upd,
    input logic                    cmd_err
);

    AST_UPD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(upd)); // R9

    AST_ERR_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> (upd == '0)); // R7

    AST_VOL_FINE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(vol_code[2:0]) <= FINE_MAX); // R7

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sel_code) <= FINE_MAX); // R4

    AST_VOL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd[UPD_VOL] |-> $stable(vol_code)); // R9

    AST_SPK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd[UPD_SEL-1:UPD_SPK0] == '0) |-> $stable(spk_code)); // R3

    AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|upd || cmd_err) |-> ($past(byte_valid) && !$past(start_det) && !$past(stop_det))); // R11

    AST_TONE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(bass_db) >= -30) && ($signed(bass_db) <= 30)); // R6

endmodule

bind audcmd_top audcmd_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .byte_valid (byte_valid),
    .vol_code   (vol_code),
    .spk_code   (spk_code),
    .sel_code   (sel_code),
    .bass_db    (bass_db),
    .upd        (upd),
    .cmd_err    (cmd_err)
);

// File: tb/audcmd_top_tb_top.sv
module audcmd_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ADDR = 8'h88;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_det = 1'b0;
    logic        stop_det = 1'b0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic [5:0]  vol_code;
    logic [8:0]  vol_db;
    logic [19:0] spk_code;
    logic [35:0] spk_db;
    logic [2:0]  sel_code;
    logic [3:0]  bass_code;
    logic [7:0]  bass_db;
    logic [3:0]  treble_code;
    logic [7:0]  treble_db;
    logic [7:0]  upd;
    logic        cmd_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    logic [5:0] m_vol;
    logic [4:0] m_spk [4];
    logic [2:0] m_sel;
    logic [3:0] m_bass, m_treb;
    logic [7:0] m_upd;
    logic       m_err;
    int         m_phase; // 0 idle, 1 addr, 2 open, 3 skip

    always #(CLK_PERIOD/2) clk = ~clk;

    audcmd_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_det(start_det), .stop_det(stop_det),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .vol_code(vol_code), .vol_db(vol_db), .spk_code(spk_code), .spk_db(spk_db),
        .sel_code(sel_code), .bass_code(bass_code), .bass_db(bass_db),
        .treble_code(treble_code), .treble_db(treble_db), .upd(upd), .cmd_err(cmd_err)
    );

    function automatic int exp_vol(input logic [5:0] c);
        return 20 - 20 * int'(c[5:3]) - 4 * int'(c[2:0]);
    endfunction

    function automatic int exp_spk(input logic [4:0] c);
        return -(20 * int'(c[4:3]) + 4 * int'(c[2:0]));
    endfunction

    function automatic int exp_tone(input logic [3:0] c);
        case (c)
            4'd0, 4'd1: return -30;
            4'd2:  return -25;
            4'd3:  return -20;
            4'd4:  return -15;
            4'd5:  return -10;
            4'd6:  return -5;
            4'd7:  return 0;
            4'd15: return 0;
            4'd14: return 5;
            4'd13: return 10;
            4'd12: return 15;
            4'd11: return 20;
            4'd10: return 25;
            default: return 30;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        n_vec++;
        cmp(tag, "vol_code", int'(vol_code), int'(m_vol));
        cmp(tag, "vol_db", int'($signed(vol_db)), exp_vol(m_vol));
        for (int i = 0; i < 4; i++) begin
            cmp(tag, "spk_code", int'(spk_code[i*5 +: 5]), int'(m_spk[i]));
            cmp(tag, "spk_db", int'($signed(spk_db[i*9 +: 9])), exp_spk(m_spk[i]));
        end
        cmp(tag, "sel_code", int'(sel_code), int'(m_sel));
        cmp(tag, "bass_code", int'(bass_code), int'(m_bass));
        cmp(tag, "bass_db", int'($signed(bass_db)), exp_tone(m_bass));
        cmp(tag, "treble_code", int'(treble_code), int'(m_treb));
        cmp(tag, "treble_db", int'($signed(treble_db)), exp_tone(m_treb));
        cmp(tag, "upd", int'(upd), int'(m_upd));
        cmp(tag, "cmd_err", int'(cmd_err), int'(m_err));
    endtask

    task automatic model_reset();
        m_vol = 6'b111100;
        for (int i = 0; i < 4; i++) m_spk[i] = 5'b11100;
        m_sel = 3'd4; m_bass = 4'b1110; m_treb = 4'b1110;
        m_upd = '0; m_err = 1'b0; m_phase = 0;
    endtask

    task automatic model_cmd(input logic [7:0] b);
        m_upd = '0; m_err = 1'b0;
        if (b[7]) begin
            if (b[2:0] > 3'd4) m_err = 1'b1;
            else begin m_spk[b[6:5]] = b[4:0]; m_upd[1 + int'(b[6:5])] = 1'b1; end
        end else if (b[7:6] == 2'b00) begin
            if (b[2:0] > 3'd4) m_err = 1'b1;
            else begin m_vol = b[5:0]; m_upd[0] = 1'b1; end
        end else if (b[7:5] == 3'b010) begin
            if (b[2:0] > 3'd4) m_err = 1'b1;
            else begin m_sel = b[2:0]; m_upd[5] = 1'b1; end
        end else if (b[7:4] == 4'b0110) begin
            m_bass = b[3:0]; m_upd[6] = 1'b1;
        end else begin
            m_treb = b[3:0]; m_upd[7] = 1'b1;
        end
    endtask

    // one cycle with the given controls; outputs checked after the edge
    task automatic cycle(input logic st, input logic sp, input logic bv,
                         input logic [7:0] b, input string tag);
        @(negedge clk);
        start_det = st; stop_det = sp; byte_valid = bv; byte_data = b;
        @(negedge clk);
        start_det = 1'b0; stop_det = 1'b0; byte_valid = 1'b0;
        m_upd = '0; m_err = 1'b0;
        if (st) m_phase = 1;
        else if (sp) m_phase = 0;
        else if (bv) begin
            if (m_phase == 1) m_phase = (b == ADDR) ? 2 : 3;
            else if (m_phase == 2) model_cmd(b);
        end
        check_all(tag);
    endtask

    task automatic send(input logic [7:0] b, input string tag);
        cycle(1'b0, 1'b0, 1'b1, b, tag);
    endtask

    task automatic open_xfer(input string tag);
        cycle(1'b1, 1'b0, 1'b0, 8'h00, tag);
        send(ADDR, tag);
    endtask

    task automatic close_xfer(input string tag);
        cycle(1'b0, 1'b1, 1'b0, 8'h00, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R8 reset defaults");

        // R1: bytes while idle are ignored
        send(8'h21, "R1 idle byte");
        // R1: foreign address leaves commands unapplied
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R1 start");
        send(8'h8A, "R1 wrong addr");
        send(8'h21, "R1 skip byte");
        send(8'h61, "R1 skip byte2");
        close_xfer("R1 stop");

        // R2, R3, R4 directed with R10 multiple bytes
        open_xfer("R10 open");
        send(8'h21, "R2 vol -32dB");
        send(8'h00, "R2 vol +10dB");
        send(8'hB2, "R3 RF -24dB");
        send(8'hE4, "R3 RR max");
        send(8'h80, "R3 LF zero");
        send(8'h41, "R4 stereo2");
        send(8'h5B, "R4 dont care bits");
        send(8'h44, "R4 mono");
        // R5/R6: every tone code
        for (int c = 0; c < 16; c++) send({4'b0110, 4'(c)}, "R5 R6 bass sweep");
        for (int c = 0; c < 16; c++) send({4'b0111, 4'(c)}, "R5 R6 treble sweep");
        // R7 rejects
        send(8'h05, "R7 vol fine 5");
        send(8'h3F, "R7 vol fine 7");
        send(8'hA6, "R7 spk fine 6");
        send(8'h45, "R7 sel 5");
        send(8'h5F, "R7 sel 7");
        send(8'h3C, "R2 vol -68dB");
        close_xfer("R10 close");
        send(8'h00, "R1 after stop");

        // R11 byte with start then command must not apply (address still pending)
        cycle(1'b1, 1'b0, 1'b1, ADDR, "R11 byte with start");
        send(8'h12, "R11 first byte is address");
        open_xfer("R11 reopen");
        cycle(1'b0, 1'b1, 1'b1, 8'h30, "R11 byte with stop");
        send(8'h30, "R11 idle after stop");
        open_xfer("R11 reopen2");
        cycle(1'b1, 1'b1, 1'b0, 8'h00, "R11 start and stop");
        send(ADDR, "R11 addr after restart");
        send(8'h09, "R2 vol after restart");
        close_xfer("R11 close");

        // random transfers
        for (int t = 0; t < 400; t++) begin
            int nb;
            cycle(1'b1, 1'b0, 1'b0, 8'h00, "R1 rnd start");
            send(($urandom % 4 == 0) ? 8'($urandom) : ADDR, "R1 rnd addr");
            nb = 1 + int'($urandom % 8);
            for (int k = 0; k < nb; k++) begin
                int r;
                r = int'($urandom % 16);
                if (r == 0)      cycle(1'b1, 1'b0, 1'b1, 8'($urandom), "R11 rnd start+byte");
                else if (r == 1) cycle(1'b0, 1'b1, 1'b1, 8'($urandom), "R11 rnd stop+byte");
                else             send(8'($urandom), "R9 rnd cmd");
            end
            close_xfer("R10 rnd stop");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule